// File: doc/BRIEF.md
# Streaming Multi-Word Right Shifter

This block shifts an arbitrarily long unsigned integer right by 0 to 63 bit positions while the integer streams through it. The integer arrives as a sequence of 64-bit digits, least-significant digit first, over a valid/ready handshake. The shifted integer leaves in the same order over a second valid/ready handshake.

Each result digit combines two input digits: the digit at the same position and the next more significant one. The pair is treated as one 128-bit value, shifted right, and cut down to its low 64 bits. The most significant digit has no upper neighbour, so zeros enter from the top.

A one-cycle `start_i` pulse loads the shift amount for the next operand. `in_last_i` marks that operand's most significant digit, which sets how many digits the operand has. Whole-digit shifts of 64 bits or more are left to the surrounding logic, which can simply skip digits.

Top module: `bigint_rshift`

## Requirements
- R1: For every result digit except the most significant, the output equals `in[i] >> s` ORed with `in[i+1] << (64 - s)`. This is the low 64 bits of the 128-bit value {in[i+1], in[i]} shifted right by s.
- R2: The most significant result digit of an operand equals `in[N-1] >> s`, with zeros entering from the top.
- R3: The shift amount s is taken from `shamt_i[5:0]`. Bits `shamt_i[7:6]` have no effect on any result digit.
- R4: With s = 0, every digit leaves unchanged.
- R5: `shamt_i` is sampled only in a cycle where `start_i` is 1. That value applies to every digit of the operand that follows, including a first digit accepted in the same cycle. A digit still held from the previous operand keeps the shift it was accepted with.
- R6: Result digit i becomes valid only when input digit i+1 is presented with `in_valid_i` = 1, or when digit i was accepted with `in_last_i` = 1. In the first case `out_valid_o` rises combinationally in that same cycle. In the second case it rises in the cycle after acceptance.
- R7: While `out_valid_o` = 1 and `out_ready_i` = 0, `out_data_o` stays stable and no input is accepted. Every accepted digit is emitted exactly once, and in order.
- R8: A one-digit operand (`in_last_i` = 1 on its first digit) yields one result equal to `in[0] >> s`.
- R9: While `rst_ni` = 0, `out_valid_o` = 0 and `in_ready_o` = 1.
- R10: `out_last_o` = 1 exactly on the result digit derived from the digit that carried `in_last_i` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Loads the shift amount for the next operand |
| shamt_i | input | 8 | Shift operand; the low 6 bits are used |
| in_valid_i | input | 1 | Input digit valid |
| in_data_i | input | 64 | Input digit |
| in_last_i | input | 1 | Input digit is the operand's most significant |
| in_ready_o | output | 1 | Input digit accepted when high with in_valid_i |
| out_valid_o | output | 1 | Result digit valid |
| out_data_o | output | 64 | Result digit |
| out_last_o | output | 1 | Result digit is the operand's most significant |
| out_ready_i | input | 1 | Downstream accepts the result digit |

## Verification
A non-top result digit is due in the same cycle that its upper neighbour is presented at the input, after no register stage. A top digit is due one cycle after its own acceptance. The bench drives inputs on the falling edge and samples 2 ns later, before the next rising edge, so both of these cases are visible in the cycle where they apply. In every such cycle it predicts `out_valid_o` from a record of the digits accepted and emitted so far. On every handshake it compares data and the last flag with values computed from the stored operands. Random stalls on both sides exercise stability under backpressure and the handover of the shift amount between back-to-back operands.

// File: rtl/bigint_rs_pkg.sv
`timescale 1ns/1ps
package bigint_rs_pkg;
  parameter int unsigned DIGIT_W = 64;
  localparam int unsigned SH_W = $clog2(DIGIT_W);

  typedef struct packed {
    logic [DIGIT_W-1:0] data;
    logic [SH_W-1:0]    sh;
    logic               last;
  } held_t;
endpackage

// File: rtl/bigint_rs_funnel.sv
`timescale 1ns/1ps
module bigint_rs_funnel #(
  parameter int unsigned DW = 64,
  localparam int unsigned SW = $clog2(DW)
) (
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] hi_i,
  input  logic [SW-1:0] sh_i,
  output logic [DW-1:0] dig_o
);
  logic [2*DW-1:0] wide;

  always_comb begin
    wide  = {hi_i, lo_i} >> sh_i;
    dig_o = wide[DW-1:0];
  end

  always_comb begin
    if (!$isunknown({lo_i, hi_i, sh_i})) begin
      a_r4_zero_pass: assert (sh_i != '0 || dig_o == lo_i);
      a_r2_zero_fill: assert (hi_i != '0 || dig_o == (lo_i >> sh_i));
    end
  end
endmodule

// File: rtl/bigint_rs_stage.sv
`timescale 1ns/1ps
module bigint_rs_stage
  import bigint_rs_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [SH_W-1:0]    sh_i,
  input  logic               in_valid_i,
  input  logic [DIGIT_W-1:0] in_data_i,
  input  logic               in_last_i,
  output logic               in_ready_o,
  output logic               emit_o,
  output logic               last_o,
  output logic [DIGIT_W-1:0] lo_o,
  output logic [DIGIT_W-1:0] hi_o,
  output logic [SH_W-1:0]    sh_o,
  input  logic               out_ready_i
);
  held_t           hold_q;
  logic            hold_v_q;
  logic [SH_W-1:0] sh_q;
  logic [SH_W-1:0] sh_cur;
  logic            fire_out;
  logic            take;

  // shift amount in force for a digit accepted this cycle
  assign sh_cur     = start_i ? sh_i : sh_q;
  assign emit_o     = hold_v_q && (hold_q.last || in_valid_i);
  assign fire_out   = emit_o && out_ready_i;
  // a held top digit must drain before the next operand enters
  assign in_ready_o = !hold_v_q || (!hold_q.last && out_ready_i);
  assign take       = in_valid_i && in_ready_o;

  assign last_o = hold_q.last;
  assign lo_o   = hold_q.data;
  assign hi_o   = hold_q.last ? '0 : in_data_i;
  assign sh_o   = hold_q.sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      hold_q   <= '0;
      hold_v_q <= 1'b0;
    end else begin
      if (start_i) sh_q <= sh_i;
      if (take) begin
        hold_q   <= '{data: in_data_i, sh: sh_cur, last: in_last_i};
        hold_v_q <= 1'b1;
      end else if (fire_out) begin
        hold_v_q <= 1'b0;
      end
    end
  end

  a_r7_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_v_q && !fire_out |=> hold_v_q && $stable(hold_q));
  a_r6_merge_fires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && hold_v_q |-> emit_o && out_ready_i);
  a_r10_last_drains: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_out && hold_q.last |=> !hold_v_q);
  a_r9_idle_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_v_q |-> in_ready_o && !emit_o);
endmodule

// File: rtl/bigint_rshift.sv
`timescale 1ns/1ps
module bigint_rshift
  import bigint_rs_pkg::*;
#(
  parameter int unsigned SHAMT_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic               in_valid_i,
  input  logic [DIGIT_W-1:0] in_data_i,
  input  logic               in_last_i,
  output logic               in_ready_o,
  output logic               out_valid_o,
  output logic [DIGIT_W-1:0] out_data_o,
  output logic               out_last_o,
  input  logic               out_ready_i
);
  logic [DIGIT_W-1:0] lo, hi;
  logic [SH_W-1:0]    sh;
  logic               unused_shamt_hi;

  assign unused_shamt_hi = ^shamt_i[SHAMT_W-1:SH_W];

  bigint_rs_stage u_stage (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .sh_i        (shamt_i[SH_W-1:0]),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .in_last_i   (in_last_i),
    .in_ready_o  (in_ready_o),
    .emit_o      (out_valid_o),
    .last_o      (out_last_o),
    .lo_o        (lo),
    .hi_o        (hi),
    .sh_o        (sh),
    .out_ready_i (out_ready_i)
  );

  bigint_rs_funnel #(.DW(DIGIT_W)) u_funnel (
    .lo_i  (lo),
    .hi_i  (hi),
    .sh_i  (sh),
    .dig_o (out_data_o)
  );
endmodule

// File: tb/bigint_rshift_tb.sv
`timescale 1ns/1ps
module bigint_rshift_tb;
  localparam int MAXD = 256;
  localparam int LIMIT = 20000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  shamt_i = '0;
  logic        in_valid_i = 1'b0;
  logic [63:0] in_data_i = '0;
  logic        in_last_i = 1'b0;
  logic        in_ready_o;
  logic        out_valid_o;
  logic [63:0] out_data_o;
  logic        out_last_o;
  logic        out_ready_i = 1'b0;

  always #2.5 clk_i = ~clk_i;

  bigint_rshift u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .shamt_i(shamt_i),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_last_i(in_last_i),
    .in_ready_o(in_ready_o), .out_valid_o(out_valid_o), .out_data_o(out_data_o),
    .out_last_o(out_last_o), .out_ready_i(out_ready_i)
  );

  logic [63:0] gd    [MAXD];
  bit          glast [MAXD];
  bit          glead [MAXD];
  logic [7:0]  graw  [MAXD];
  int          gtag  [MAXD];
  int          total = 0;
  int          n_cmp = 0;
  int          n_bad = 0;

  task automatic add_op(int n, logic [7:0] raw, int tag);
    for (int k = 0; k < n; k++) begin
      gd[total]    = {$urandom, $urandom};
      glast[total] = (k == n - 1);
      glead[total] = (k == 0);
      graw[total]  = raw;
      gtag[total]  = tag;
      total++;
    end
  endtask

  function automatic logic [63:0] expect_dig(int g);
    int s;
    logic [63:0] upper;
    s = int'(graw[g][5:0]);
    upper = glast[g] ? 64'd0 : gd[g + 1];
    if (s == 0) return gd[g];
    return (gd[g] >> s) | (upper << (64 - s));
  endfunction

  function automatic string req_of(int g);
    if (gtag[g] == 5) return "R5";
    if (glead[g] && glast[g]) return "R8";
    if (graw[g][5:0] == 0) return "R4";
    if (graw[g][7:6] != 0) return "R3";
    return glast[g] ? "R2" : "R1";
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    int acc = 0, emitted = 0;
    bit started = 0, drop = 0, stalled = 0, exp_v;
    logic [63:0] prev_data = '0;

    add_op(4, 8'd12, 0);   // R1, R2
    add_op(1, 8'd37, 0);   // R8
    add_op(3, 8'd0, 0);    // R4
    add_op(5, 8'hC5, 0);   // R3: upper bits set, s = 5
    add_op(2, 8'd63, 0);   // R2 extreme
    add_op(6, 8'd1, 0);
    for (int i = 0; i < 20; i++) add_op(1 + int'($urandom % 8), 8'($urandom), 5); // R5

    repeat (3) @(negedge clk_i);
    #2;
    chk(in_ready_o == 1'b1, "R9", 64'(in_ready_o), 64'd1);
    chk(out_valid_o == 1'b0, "R9", 64'(out_valid_o), 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int cyc = 0; cyc < LIMIT && emitted < total; cyc++) begin
      @(negedge clk_i);
      if (drop) begin in_valid_i = 1'b0; drop = 0; end
      start_i = 1'b0;
      shamt_i = 8'($urandom);
      if (acc < total && glead[acc] && !started) begin
        start_i = 1'b1;
        shamt_i = graw[acc];
        started = 1;
      end
      if (acc < total && started) begin
        if (!in_valid_i) in_valid_i = ($urandom % 4) != 0;
        in_data_i = gd[acc];
        in_last_i = glast[acc];
      end else begin
        in_valid_i = 1'b0;
      end
      out_ready_i = ($urandom % 4) != 0;
      #2;
      // R6: result i due once digit i+1 is presented or digit i was the top
      exp_v = (emitted < acc) && (glast[emitted] || in_valid_i);
      chk(out_valid_o == exp_v, "R6", 64'(out_valid_o), 64'(exp_v));
      if (stalled && out_valid_o) chk(out_data_o == prev_data, "R7", out_data_o, prev_data);
      if (out_valid_o && out_ready_i && emitted < total) begin
        chk(out_data_o == expect_dig(emitted), req_of(emitted), out_data_o, expect_dig(emitted));
        chk(out_last_o == glast[emitted], "R10", 64'(out_last_o), 64'(glast[emitted]));
        emitted++;
      end
      stalled = out_valid_o && !out_ready_i;
      prev_data = out_data_o;
      if (in_valid_i && in_ready_o) begin
        acc++;
        drop = 1;
        if (acc < total && glead[acc]) started = 0;
      end
    end

    if (emitted < total) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R7: watchdog, actual %0d emitted expected %0d", emitted, total);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule